// File: doc/BRIEF.md
# AES3 User-Bit Double Buffer

This block supplies the user (U) bit for each subframe an AES3 transmitter sends. It has two modes. In the silent mode, every U bit it returns is zero, whatever data has been loaded. In the block mode, a whole block of user data is held in two buffers. A host fills the first buffer, and at each block boundary that buffer is copied into a second buffer. The transmit side reads only the second buffer. As a result, a block is always sent from one consistent snapshot, even while the host is rewriting the data for the next block.

The host loads 16-bit words through a byte-wide port. It gives a word address first, then sends the high byte, then the low byte. In each word, the bits of the A and B subframes alternate, starting with the most significant bit. The framer pulses a block-start strobe once per block. After that it issues one request per subframe and gives an A/B flag with each request. The block answers each request in the same cycle.

Top module: `aes3_ubit_mgr`

## Requirements
- R1: While the silent mode is in force (`blk_mode_q` = 0), `u_bit` is 0 on every request, whatever the host buffer holds.
- R2: After reset, the silent mode is in force and both buffers hold zeros. A block-mode block started before any host write sends only zeros.
- R3: A host write is `hw_addr_we` with a word address, then a `hw_data_we` byte that is the high byte, then a second `hw_data_we` byte that is the low byte. The word commits on the low byte. Addresses 24 and above change nothing.
- R4: If a new address strobe arrives while only the high byte is held, the held byte is discarded. The next two bytes form the word at the new address, and the old address keeps its previous word.
- R5: `blk_start` copies the whole host buffer into the transmit buffer. Host writes made after that copy do not affect the block being sent. They appear from the next `blk_start` on.
- R6: A word whose low byte arrives in the same cycle as `blk_start` is held back. The block that starts in that cycle sends the previous value of that word. The new value is in place for the following block.
- R7: Bit order: word w covers frames 8w to 8w+7. Bit 15 is the A bit of frame 8w and bit 14 is its B bit, and so on down to bit 1 (A, frame 8w+7) and bit 0 (B, frame 8w+7). `u_bit` for a request with `sf_is_b` = b in frame f equals bit 15-2(f mod 8)-b of word f/8.
- R8: The frame pointer returns to frame 0 at `blk_start`. It moves to the next frame after each request with `sf_is_b` = 1, and wraps from frame 191 back to frame 0.
- R9: `blk_mode` is sampled only on `blk_start` (1 = block mode, 0 = silent). Changing it in the middle of a block leaves that block unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_start | input | 1 | One-cycle block boundary strobe; triggers the copy |
| blk_mode | input | 1 | Mode for the next block: 1 block data, 0 all zeros |
| hw_addr_we | input | 1 | Host address strobe |
| hw_addr | input | 5 | Host word address |
| hw_data_we | input | 1 | Host byte strobe |
| hw_data | input | 8 | Host byte, high byte first |
| sf_req | input | 1 | Subframe request for a U bit |
| sf_is_b | input | 1 | Current subframe is B (1) or A (0) |
| u_bit | output | 1 | U bit for the current request |

## Verification
The hardest case to reach from the ports is a low byte that lands in exactly the same cycle as the block-start strobe. To get there, the driver sends the address and the high byte in the cycles before the boundary, then raises the low byte together with `blk_start`. The scoreboard expects the old word for the block that follows and the new word for the block after it. The stimulus also changes `blk_mode` partway through blocks and writes words for frames that have not yet been sent. This shows that neither change reaches the block already running. It also runs past 192 frames without a strobe, so the pointer has to wrap.

// File: rtl/aes3_ubit_mgr.sv
module aes3_ubit_mgr #(
  parameter int FRAMES = 192
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       blk_start,
  input  logic       blk_mode,
  input  logic       hw_addr_we,
  input  logic [4:0] hw_addr,
  input  logic       hw_data_we,
  input  logic [7:0] hw_data,
  input  logic       sf_req,
  input  logic       sf_is_b,
  output logic       u_bit
);
  localparam int WW     = 16;
  localparam int BITS   = 2 * FRAMES;
  localparam int NWORDS = BITS / WW;
  localparam int FW     = $clog2(FRAMES);

  logic [BITS-1:0] usr_flat, tx_flat;
  logic            blk_mode_q;
  logic [FW-1:0]   fptr;
  logic [4:0]      addr_q, pend_addr;
  logic [7:0]      hi_byte;
  logic            hi_vld;
  logic [WW-1:0]   pend_word;
  logic            pend_vld;

  wire commit    = hw_data_we && hi_vld && !hw_addr_we;
  wire commit_ok = commit && (32'(addr_q) < NWORDS);
  wire [FW:0] bit_n = {fptr, sf_is_b};
  wire [FW:0] flat_idx = {bit_n[FW:4], ~bit_n[3:0]};

  assign u_bit = blk_mode_q & tx_flat[flat_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      usr_flat   <= '0;
      tx_flat    <= '0;
      blk_mode_q <= 1'b0;
      fptr       <= '0;
      addr_q     <= '0;
      hi_byte    <= '0;
      hi_vld     <= 1'b0;
      pend_addr  <= '0;
      pend_word  <= '0;
      pend_vld   <= 1'b0;
    end else begin
      if (blk_start) begin
        tx_flat    <= usr_flat;
        blk_mode_q <= blk_mode;
        fptr       <= '0;
      end else if (sf_req && sf_is_b) begin
        fptr <= (fptr == FW'(FRAMES - 1)) ? '0 : fptr + 1'b1;
      end

      if (hw_addr_we) begin
        addr_q  <= hw_addr;
        hi_vld  <= hw_data_we;
        hi_byte <= hw_data;
      end else if (hw_data_we) begin
        hi_vld  <= !hi_vld;
        if (!hi_vld) hi_byte <= hw_data;
      end

      pend_vld <= commit_ok && blk_start;
      if (commit_ok && blk_start) begin
        pend_addr <= addr_q;
        pend_word <= {hi_byte, hw_data};
      end
      if (pend_vld)
        usr_flat[int'(pend_addr)*WW +: WW] <= pend_word;
      if (commit_ok && !blk_start)
        usr_flat[int'(addr_q)*WW +: WW] <= {hi_byte, hw_data};
    end
  end

  a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_start |=> $stable(blk_mode_q));
  a_r8_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fptr) < FRAMES);
  a_r8_ptr_restart: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |=> fptr == '0);
  a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_start |=> $stable(tx_flat));
  a_r6_pend_once: assert property (@(posedge clk) disable iff (!rst_n)
    pend_vld |=> !pend_vld);
  a_r6_pend_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_vld) |-> $past(blk_start));
  a_r3_range_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !(32'(addr_q) < NWORDS) && !pend_vld) |=> $stable(usr_flat));
endmodule

// File: tb/aes3_ubit_mgr_tb.sv
module aes3_ubit_mgr_tb;
  localparam int NW = 24;
  localparam int FR = 192;

  logic clk = 0, rst_n = 0;
  logic blk_start = 0, blk_mode = 0, hw_addr_we = 0, hw_data_we = 0;
  logic [4:0] hw_addr = 0;
  logic [7:0] hw_data = 0;
  logic sf_req = 0, sf_is_b = 0;
  logic u_bit;

  aes3_ubit_mgr u_dut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  logic  exp_q[$];
  string tag_q[$];
  logic [15:0] usrm [NW];
  logic [15:0] txm  [NW];
  logic mode_m = 0;
  int fm = 0;
  bit bm = 0;

  function automatic logic exp_bit(int f, bit b);
    if (!mode_m) return 1'b0;
    return txm[f/8][15 - 2*(f%8) - int'(b)];
  endfunction

  always @(negedge clk) begin
    #3;
    if (sf_req) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: unexpected request, actual=%0b expected=none", u_bit);
      end else begin
        logic e; string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (u_bit !== e) begin
          errors++;
          $display("FAIL %s: frame-bit u_bit actual=%0b expected=%0b", t, u_bit, e);
        end
      end
    end
  end

  task automatic run_req(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sf_req = 1; sf_is_b = bm;
      exp_q.push_back(exp_bit(fm, bm));
      tag_q.push_back(tag);
      if (bm) fm = (fm + 1) % FR;
      bm = !bm;
    end
    @(negedge clk);
    sf_req = 0;
  endtask

  task automatic host_write(int a, logic [15:0] d);
    @(negedge clk); hw_addr_we = 1; hw_addr = 5'(a);
    @(negedge clk); hw_addr_we = 0; hw_data_we = 1; hw_data = d[15:8];
    @(negedge clk); hw_data = d[7:0];
    @(negedge clk); hw_data_we = 0;
    if (a < NW) usrm[a] = d;
  endtask

  // R4: lone high byte dropped when a new address arrives
  task automatic lone_then(int a_old, int a_new, logic [7:0] stray, logic [15:0] d);
    @(negedge clk); hw_addr_we = 1; hw_addr = 5'(a_old);
    @(negedge clk); hw_addr_we = 0; hw_data_we = 1; hw_data = stray;
    @(negedge clk); hw_data_we = 0; hw_addr_we = 1; hw_addr = 5'(a_new);
    @(negedge clk); hw_addr_we = 0;
    host_bytes(d);
    usrm[a_new] = d;
  endtask

  task automatic host_bytes(logic [15:0] d);
    @(negedge clk); hw_data_we = 1; hw_data = d[15:8];
    @(negedge clk); hw_data = d[7:0];
    @(negedge clk); hw_data_we = 0;
  endtask

  task automatic block_begin(logic m, bit held, int ha, logic [15:0] hd);
    if (held) begin
      @(negedge clk); hw_addr_we = 1; hw_addr = 5'(ha);
      @(negedge clk); hw_addr_we = 0; hw_data_we = 1; hw_data = hd[15:8];
    end
    @(negedge clk);
    blk_start = 1; blk_mode = m;
    if (held) hw_data = hd[7:0];
    mode_m = m;
    for (int w = 0; w < NW; w++) txm[w] = usrm[w];
    fm = 0; bm = 0;
    if (held) usrm[ha] = hd;
    @(negedge clk);
    blk_start = 0; hw_data_we = 0;
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int w = 0; w < NW; w++) begin usrm[w] = '0; txm[w] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2: silent after reset even with block mode requested
    checks++;
    if (u_bit !== 1'b0) begin errors++; $display("FAIL R2: reset u_bit actual=%0b expected=0", u_bit); end
    blk_mode = 1;
    run_req(6, "R2");
    block_begin(1, 0, 0, 0);
    run_req(48, "R2");
    // R3: fill all words, plus an out-of-range address
    for (int w = 0; w < NW; w++) host_write(w, 16'(w * 16'h1F3B + 16'h5A17));
    host_write(30, 16'hFFFF);
    host_write(27, 16'hFFFF);
    // R1 and R9: silent block, mode flipped midway
    block_begin(0, 0, 0, 0);
    blk_mode = 1;
    run_req(384, "R1");
    // R7: full block of data
    block_begin(1, 0, 0, 0);
    run_req(384, "R7");
    // R5: rewrite a word not yet sent during the block
    block_begin(1, 0, 0, 0);
    run_req(100, "R8");
    host_write(20, 16'hC33C);
    blk_mode = 0;
    run_req(284, "R5");
    // R8: wrap without a strobe, mode change ignored (R9)
    run_req(420, "R8");
    // R4
    lone_then(7, 9, 8'hEE, 16'h1234);
    block_begin(1, 0, 0, 0);
    run_req(384, "R4");
    // R6: low byte with block start
    block_begin(1, 1, 11, 16'hBEEF);
    run_req(384, "R6");
    block_begin(1, 0, 0, 0);
    run_req(384, "R6");
    block_begin(0, 0, 0, 0);
    run_req(64, "R1");
    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard: leftover actual=%0d expected=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule